// File: doc/BRIEF.md
# Disk Controller Register Window Decoder

This block sits behind a 4 KB host register window and turns host accesses into strobes on an attached parallel disk-interface register bus. Each register occupies its own 16-byte slot, so the slot number is the host address with its low four bits dropped. Every slot accepts only certain access sizes. The data port takes halfword or word accesses. The task-file registers and the status/command register take single bytes. Two different slots both reach the status/command register. An access with a size the slot does not accept has no effect.

Two registers live inside the block. The first is a 32-bit timing configuration word. The second is an interrupt status word that mirrors the DMA and disk interrupt levels in its top two bits. The DMA bit can also be cleared by writing a one to it. Both interrupt levels are also forwarded unchanged to output pins.

Reads complete in one cycle. The returned word is registered on the clock edge that ends the read. Host data is little-endian, so narrow reads return their value zero-extended in the low bits.

Top module: `disk_regwin`

## Requirements
- R1: The slot number is `host_addr[11:4]`. Address bits 3:0 do not affect decoding.
- R2: Slot 0x00 is the data port. A 2-byte or 4-byte access raises `dbus_rd`/`dbus_wr` with `dbus_idx`=0. A 2-byte read returns `dbus_rdata[15:0]` zero-extended. A 4-byte read returns all 32 bits.
- R3: Slots 0x01 to 0x07 accept 1-byte accesses only. They strobe the bus with `dbus_idx` equal to the slot number, and a read returns `dbus_rdata[7:0]` zero-extended.
- R4: Slots 0x08 and 0x16 both reach the status/command register with `dbus_idx`=8, for 1-byte accesses only.
- R5: Slot 0x20 holds the timing word. A 4-byte write stores `host_wdata`, and a 4-byte read returns the stored word.
- R6: Slot 0x30 reads, with a 4-byte access only, the interrupt word. Bit 31 is the DMA source and bit 30 is the disk source; all other bits read 0. A rising level sets the bit and a falling level clears it, and the change is visible from the cycle after the level change.
- R7: `irq_dma_out` follows `irq_dma_in` and `irq_disk_out` follows `irq_disk_in` combinationally.
- R8: A 4-byte write to slot 0x30 with bit 31 set clears bit 31 of the interrupt word. The bit stays clear while the DMA level stays high. Bit 30 of the write data, and every other bit, has no effect.
- R9: A read of an unmapped slot, or a read with a size the slot does not accept, returns 0xFFFFFFFF and raises no bus strobe.
- R10: A write to an unmapped slot, or a write with a size the slot does not accept, raises no bus strobe and leaves the timing and interrupt words unchanged.
- R11: After reset the timing word, the interrupt word and `host_rdata` are all zero.
- R12: `host_rdata` changes only on the edge that ends a read. When `host_rd` and `host_wr` are both high, only the read takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 12 | Byte address within the window |
| host_size | input | 3 | Access size in bytes (1, 2 or 4) |
| host_wdata | input | 32 | Write data, little-endian |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_rdata | output | 32 | Registered read data |
| dbus_rd | output | 1 | Disk register bus read strobe |
| dbus_wr | output | 1 | Disk register bus write strobe |
| dbus_idx | output | 4 | Disk register index |
| dbus_size | output | 3 | Access size passed to the disk bus |
| dbus_wdata | output | 32 | Write data passed to the disk bus |
| dbus_rdata | input | 32 | Read data returned by the disk bus |
| irq_dma_in | input | 1 | DMA interrupt level |
| irq_disk_in | input | 1 | Disk interrupt level |
| irq_dma_out | output | 1 | Forwarded DMA interrupt |
| irq_disk_out | output | 1 | Forwarded disk interrupt |

## Verification
The hardest state to reach is an interrupt word whose DMA bit is clear while the DMA level is still high. The bench raises the DMA level and confirms that bit 31 is set. It then writes a word with only bit 30 set and checks that nothing changes. Next it writes bit 31 and reads back a cleared bit 31 while the level is still held high. Finally it drops the level and raises it again, and checks that the bit comes back.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    typedef enum logic [2:0] {
        SL_NONE,
        SL_DATA,
        SL_TASK,
        SL_STAT,
        SL_TIMING,
        SL_IRQ
    } slot_kind_e;

    typedef struct packed {
        slot_kind_e kind;
        logic [3:0] idx;
    } slot_dec_t;

    localparam logic [7:0] SLOT_DATA    = 8'h00;
    localparam logic [7:0] SLOT_TF_LAST = 8'h07;
    localparam logic [7:0] SLOT_STAT_A  = 8'h08;
    localparam logic [7:0] SLOT_STAT_B  = 8'h16;
    localparam logic [7:0] SLOT_TIMING  = 8'h20;
    localparam logic [7:0] SLOT_IRQ     = 8'h30;
    localparam logic [3:0] IDX_STATUS   = 4'd8;

endpackage

// File: rtl/regwin_decode.sv
module regwin_decode
    import regwin_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int SLOT_SHIFT = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        size,
    output slot_dec_t         dec
);
    localparam int SLOT_W = ADDR_W - SLOT_SHIFT;

    logic [SLOT_W-1:0] slot;
    logic              sz_b;
    logic              sz_h;
    logic              sz_w;

    assign slot = addr[ADDR_W-1:SLOT_SHIFT];
    assign sz_b = (size == 3'd1);
    assign sz_h = (size == 3'd2);
    assign sz_w = (size == 3'd4);

    always_comb begin
        dec.kind = SL_NONE;
        dec.idx  = '0;
        if (slot == SLOT_W'(SLOT_DATA)) begin
            if (sz_h || sz_w) begin
                dec.kind = SL_DATA;
                dec.idx  = '0;
            end
        end else if (slot <= SLOT_W'(SLOT_TF_LAST)) begin
            if (sz_b) begin
                dec.kind = SL_TASK;
                dec.idx  = slot[3:0];
            end
        end else if (slot == SLOT_W'(SLOT_STAT_A) || slot == SLOT_W'(SLOT_STAT_B)) begin
            if (sz_b) begin
                dec.kind = SL_STAT;
                dec.idx  = IDX_STATUS;
            end
        end else if (slot == SLOT_W'(SLOT_TIMING)) begin
            if (sz_w) dec.kind = SL_TIMING;
        end else if (slot == SLOT_W'(SLOT_IRQ)) begin
            if (sz_w) dec.kind = SL_IRQ;
        end
    end

endmodule

// File: rtl/regwin_irq.sv
module regwin_irq #(
    parameter int NSRC   = 2,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   lvl,
    input  logic              clr_top,
    output logic [DATA_W-1:0] stat
);
    typedef struct packed {
        logic [NSRC-1:0] prev;
        logic [NSRC-1:0] flag;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl;
        for (int n = 0; n < NSRC; n++) begin
            if (lvl[n] != st_q.prev[n]) begin
                st_d.flag[n] = lvl[n];
            end else if (n == 0 && clr_top) begin
                st_d.flag[n] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        for (genvar b = 0; b < DATA_W; b++) begin : g_bit
            if (b >= DATA_W - NSRC) begin : g_src
                assign stat[b] = st_q.flag[DATA_W-1-b];
            end else begin : g_zero
                assign stat[b] = 1'b0;
            end
        end
    endgenerate

    AST_DMA_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lvl[0]) |=> stat[DATA_W-1]); // R6
    AST_DISK_FALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lvl[1]) |=> !stat[DATA_W-2]); // R6
    AST_W1C_LOW_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_top && !lvl[0]) |=> !stat[DATA_W-1]); // R8

endmodule

// File: rtl/disk_regwin.sv
module disk_regwin
    import regwin_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int SLOT_SHIFT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [2:0]        host_size,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_rd,
    input  logic              host_wr,
    output logic [DATA_W-1:0] host_rdata,
    output logic              dbus_rd,
    output logic              dbus_wr,
    output logic [3:0]        dbus_idx,
    output logic [2:0]        dbus_size,
    output logic [DATA_W-1:0] dbus_wdata,
    input  logic [DATA_W-1:0] dbus_rdata,
    input  logic              irq_dma_in,
    input  logic              irq_disk_in,
    output logic              irq_dma_out,
    output logic              irq_disk_out
);
    localparam int NSRC = 2;
    localparam int HW_W = DATA_W / 2;

    typedef struct packed {
        logic [DATA_W-1:0] timing;
        logic [DATA_W-1:0] rdata;
    } top_st_t;

    top_st_t           st_d, st_q;
    slot_dec_t         dec;
    logic              rd_go;
    logic              wr_go;
    logic              bus_hit;
    logic              irq_clr;
    logic [DATA_W-1:0] irq_word;

    regwin_decode #(
        .ADDR_W     (ADDR_W),
        .SLOT_SHIFT (SLOT_SHIFT)
    ) u_dec (
        .addr (host_addr),
        .size (host_size),
        .dec  (dec)
    );

    regwin_irq #(
        .NSRC   (NSRC),
        .DATA_W (DATA_W)
    ) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl     ({irq_disk_in, irq_dma_in}),
        .clr_top (irq_clr),
        .stat    (irq_word)
    );

    assign rd_go   = host_rd;
    assign wr_go   = host_wr && !host_rd;
    assign bus_hit = (dec.kind == SL_DATA) || (dec.kind == SL_TASK) || (dec.kind == SL_STAT);
    assign irq_clr = wr_go && (dec.kind == SL_IRQ) && host_wdata[DATA_W-1];

    assign dbus_rd    = rd_go && bus_hit;
    assign dbus_wr    = wr_go && bus_hit;
    assign dbus_idx   = dec.idx;
    assign dbus_size  = host_size;
    assign dbus_wdata = host_wdata;

    assign irq_dma_out  = irq_dma_in;
    assign irq_disk_out = irq_disk_in;

    always_comb begin
        st_d = st_q;
        if (rd_go) begin
            case (dec.kind)
                SL_DATA:   st_d.rdata = (host_size == 3'd2) ? DATA_W'(dbus_rdata[HW_W-1:0])
                                                            : dbus_rdata;
                SL_TASK,
                SL_STAT:   st_d.rdata = DATA_W'(dbus_rdata[7:0]);
                SL_TIMING: st_d.rdata = st_q.timing;
                SL_IRQ:    st_d.rdata = irq_word;
                default:   st_d.rdata = '1;
            endcase
        end
        if (wr_go && dec.kind == SL_TIMING) begin
            st_d.timing = host_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign host_rdata = st_q.rdata;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(dbus_rd && dbus_wr)); // R12
    AST_LEGAL_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        (dbus_rd || dbus_wr) |-> (host_size == 3'd1 || host_size == 3'd2 || host_size == 3'd4)); // R10
    AST_TIMING_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && !host_rd && dec.kind == SL_TIMING) |=> $stable(st_q.timing)); // R5
    AST_MISS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && dec.kind == SL_NONE) |=> (host_rdata == '1)); // R9
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> $stable(host_rdata)); // R12

endmodule

// File: tb/disk_regwin_test.sv
module disk_regwin_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] host_addr = '0;
    logic [2:0]  host_size = '0;
    logic [31:0] host_wdata = '0;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;
    logic [31:0] host_rdata;
    logic        dbus_rd, dbus_wr;
    logic [3:0]  dbus_idx;
    logic [2:0]  dbus_size;
    logic [31:0] dbus_wdata;
    logic [31:0] dbus_rdata;
    logic        irq_dma_in = 1'b0;
    logic        irq_disk_in = 1'b0;
    logic        irq_dma_out, irq_disk_out;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    // Device model: word 0xBEEF_A0<idx>
    assign dbus_rdata = {16'hBEEF, 8'hA0, 4'h0, dbus_idx};

    disk_regwin uut (
        .clk(clk), .rst_n(rst_n),
        .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_wr(host_wr), .host_rdata(host_rdata),
        .dbus_rd(dbus_rd), .dbus_wr(dbus_wr), .dbus_idx(dbus_idx),
        .dbus_size(dbus_size), .dbus_wdata(dbus_wdata), .dbus_rdata(dbus_rdata),
        .irq_dma_in(irq_dma_in), .irq_disk_in(irq_disk_in),
        .irq_dma_out(irq_dma_out), .irq_disk_out(irq_disk_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // Write; checks strobe/idx/data while the access is on the bus.
    task automatic wr(input string req, input logic [11:0] a, input logic [2:0] sz,
                      input logic [31:0] d, input logic exp_stb, input logic [3:0] exp_idx);
        @(negedge clk);
        host_addr = a; host_size = sz; host_wdata = d; host_wr = 1'b1;
        #1;
        chk(req, {31'b0, dbus_wr}, {31'b0, exp_stb});
        chk(req, {31'b0, dbus_rd}, 32'h0);
        if (exp_stb) begin
            chk(req, {28'b0, dbus_idx}, {28'b0, exp_idx});
            chk(req, dbus_wdata, d);
            chk(req, {29'b0, dbus_size}, {29'b0, sz});
        end
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input string req, input logic [11:0] a, input logic [2:0] sz,
                      input logic [31:0] exp, input logic exp_stb);
        @(negedge clk);
        host_addr = a; host_size = sz; host_rd = 1'b1;
        #1;
        chk(req, {31'b0, dbus_rd}, {31'b0, exp_stb});
        @(negedge clk);
        host_rd = 1'b0;
        chk(req, host_rdata, exp);
    endtask

    task automatic t_reset();
        chk("R11 rdata", host_rdata, 32'h0);
        rd("R11 timing", 12'h200, 3'd4, 32'h0, 1'b0);
        rd("R11 irq", 12'h300, 3'd4, 32'h0, 1'b0);
    endtask

    task automatic t_data_port();
        wr("R2 wr32", 12'h000, 3'd4, 32'h1234_5678, 1'b1, 4'd0);
        wr("R2 wr16", 12'h00C, 3'd2, 32'h0000_9ABC, 1'b1, 4'd0);
        rd("R2 rd32", 12'h000, 3'd4, 32'hBEEF_A000, 1'b1);
        rd("R2 rd16", 12'h004, 3'd2, 32'h0000_A000, 1'b1);
        wr("R10 data byte wr", 12'h000, 3'd1, 32'h55, 1'b0, 4'd0);
        rd("R9 data byte rd", 12'h000, 3'd1, 32'hFFFF_FFFF, 1'b0);
    endtask

    task automatic t_taskfile();
        for (int s = 1; s <= 7; s++) begin
            wr("R3 tf wr", 12'(s << 4), 3'd1, 32'h0000_00C3, 1'b1, 4'(s));
            rd("R3 tf rd", 12'((s << 4) | 3), 3'd1, {24'h0, 4'h0, 4'(s)}, 1'b1);
        end
        wr("R10 tf half wr", 12'h030, 3'd2, 32'h1, 1'b0, 4'd0);
        rd("R9 tf word rd", 12'h050, 3'd4, 32'hFFFF_FFFF, 1'b0);
        rd("R1 low nibble", 12'h02F, 3'd1, 32'h0000_0002, 1'b1);
    endtask

    task automatic t_status_alias();
        rd("R4 stat 08", 12'h080, 3'd1, 32'h0000_0008, 1'b1);
        rd("R4 stat 16", 12'h160, 3'd1, 32'h0000_0008, 1'b1);
        wr("R4 cmd 08", 12'h080, 3'd1, 32'h0000_00EC, 1'b1, 4'd8);
        wr("R4 cmd 16", 12'h165, 3'd1, 32'h0000_00A0, 1'b1, 4'd8);
        rd("R9 stat half", 12'h160, 3'd2, 32'hFFFF_FFFF, 1'b0);
    endtask

    task automatic t_timing();
        wr("R5 tim wr", 12'h200, 3'd4, 32'hCAFE_F00D, 1'b0, 4'd0);
        rd("R5 tim rd", 12'h208, 3'd4, 32'hCAFE_F00D, 1'b0);
        wr("R10 tim byte", 12'h200, 3'd1, 32'h0000_0011, 1'b0, 4'd0);
        rd("R10 tim kept", 12'h200, 3'd4, 32'hCAFE_F00D, 1'b0);
        rd("R9 tim half", 12'h200, 3'd2, 32'hFFFF_FFFF, 1'b0);
    endtask

    task automatic t_unmapped();
        rd("R9 slot09", 12'h090, 3'd1, 32'hFFFF_FFFF, 1'b0);
        rd("R9 slot21", 12'h210, 3'd4, 32'hFFFF_FFFF, 1'b0);
        rd("R9 slotFF", 12'hFF0, 3'd4, 32'hFFFF_FFFF, 1'b0);
        wr("R10 slot40", 12'h400, 3'd4, 32'h8000_0000, 1'b0, 4'd0);
        rd("R10 tim after", 12'h200, 3'd4, 32'hCAFE_F00D, 1'b0);
    endtask

    task automatic t_irq();
        @(negedge clk);
        irq_dma_in = 1'b1;
        #1;
        chk("R7 dma out", {31'b0, irq_dma_out}, 32'h1);
        chk("R7 disk out", {31'b0, irq_disk_out}, 32'h0);
        rd("R6 dma set", 12'h300, 3'd4, 32'h8000_0000, 1'b0);
        @(negedge clk);
        irq_disk_in = 1'b1;
        #1;
        chk("R7 disk out hi", {31'b0, irq_disk_out}, 32'h1);
        rd("R6 both set", 12'h300, 3'd4, 32'hC000_0000, 1'b0);
        wr("R8 bit30 only", 12'h300, 3'd4, 32'h4000_0000, 1'b0, 4'd0);
        rd("R8 no effect", 12'h300, 3'd4, 32'hC000_0000, 1'b0);
        wr("R8 w1c", 12'h300, 3'd4, 32'h8000_0000, 1'b0, 4'd0);
        rd("R8 cleared level high", 12'h300, 3'd4, 32'h4000_0000, 1'b0);
        chk("R7 dma out held", {31'b0, irq_dma_out}, 32'h1);
        @(negedge clk);
        irq_disk_in = 1'b0;
        rd("R6 disk fall", 12'h300, 3'd4, 32'h0000_0000, 1'b0);
        @(negedge clk);
        irq_dma_in = 1'b0;
        @(negedge clk);
        irq_dma_in = 1'b1;
        rd("R6 dma re-rise", 12'h300, 3'd4, 32'h8000_0000, 1'b0);
        rd("R9 irq byte", 12'h300, 3'd1, 32'hFFFF_FFFF, 1'b0);
        @(negedge clk);
        irq_dma_in = 1'b0;
        rd("R6 dma fall", 12'h300, 3'd4, 32'h0000_0000, 1'b0);
    endtask

    task automatic t_rd_priority();
        @(negedge clk);
        host_addr = 12'h200; host_size = 3'd4; host_wdata = 32'h0BAD_0BAD;
        host_rd = 1'b1; host_wr = 1'b1;
        #1;
        chk("R12 no bus wr", {31'b0, dbus_wr}, 32'h0);
        @(negedge clk);
        host_rd = 1'b0; host_wr = 1'b0;
        chk("R12 read wins", host_rdata, 32'hCAFE_F00D);
        @(negedge clk);
        chk("R12 rdata held", host_rdata, 32'hCAFE_F00D);
        rd("R12 tim untouched", 12'h200, 3'd4, 32'hCAFE_F00D, 1'b0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_data_port();
        t_taskfile();
        t_status_alias();
        t_timing();
        t_unmapped();
        t_irq();
        t_rd_priority();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule